// File: doc/BRIEF.md
# Free-Running Tick Timer

This block is a 12-bit up-counter that advances once for every pulse on a 1 MHz enable input derived from the system clock. It starts counting as soon as reset is released, never stops, and cannot be loaded. It wraps from its all-ones value back to zero and has no overflow flag. Two periodic interrupt requests come from the same counter. A short-period request fires every 128 ticks (128 µs). A long-period request fires every 1024 ticks (1.024 ms).

Firmware reads the count through two read-only byte registers on a small read port. A read of the low byte also copies the upper four counter bits into a holding register. A read of the high byte returns that holding register. Reading low first and then high therefore gives a 12-bit value that stays consistent even when a carry into the upper bits happens between the two reads.

Top module: `tick_timer`

## Requirements
- R1: After reset is released, the counter increases by exactly one on each clock edge where `tickEn` is high. It holds its value on edges where `tickEn` is low.
- R2: A read with `rdAddr` = 0 returns counter bits 7:0 on `rdData` in the same cycle as `rdEn`.
- R3: `irqShort` is high for exactly one clock, in the cycle after the edge where a tick carries counter bits 6:0 from 0x7F to 0x00.
- R4: `irqLong` is high for exactly one clock, in the cycle after the edge where a tick carries counter bits 9:0 from 0x3FF to 0x000. Every `irqLong` pulse coincides with an `irqShort` pulse.
- R5: A read with `rdAddr` = 0 copies counter bits 11:8 into a holding register at that clock edge. A read with `rdAddr` = 1 returns the holding register in `rdData` bits 3:0, even if the counter has carried since the copy.
- R6: A synchronous reset (`rst` high at an edge) clears the counter and the holding register to zero. It raises no interrupt in the following cycle, even if `tickEn` is high and the counter would have rolled over.
- R7: The counter wraps from 0xFFF to 0x000 on a tick with no other effect. The wrap raises both interrupts, because bits 9:0 and 6:0 both roll over.
- R8: `rdData` bits 7:4 read zero for `rdAddr` = 1, and all of `rdData` reads zero when `rdEn` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tickEn | input | 1 | One-clock enable pulse at 1 MHz |
| rdEn | input | 1 | Read strobe |
| rdAddr | input | 1 | Register select: 0 = low byte, 1 = high byte |
| rdData | output | 8 | Read data, valid in the cycle of `rdEn` |
| irqShort | output | 1 | One-clock request every 128 ticks |
| irqLong | output | 1 | One-clock request every 1024 ticks |

## Verification
The counter is driven with a tick on every clock and with sparse ticks every fifth clock. The dense pattern runs through full 4096-tick wraps quickly. The sparse pattern separates counting on ticks from counting on clocks, and shows that an interrupt lasts one clock and not one tick period. Low/high read pairs are placed right at a 0xFF-to-0x100 carry, so a missing snapshot shows up as a torn value. A reset applied at the exact edge where bits 6:0 would roll over shows whether reset suppresses the request.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  // Strobes handed from control to datapath each cycle
  typedef struct packed {
    logic advance;    // increment the counter
    logic captureHi;  // copy upper counter bits into the holding register
    logic readOn;     // a read is in progress this cycle
    logic selHi;      // read selects the high byte
  } tmrStrobe_t;

  localparam int unsigned LO_SEL = 0;
  localparam int unsigned HI_SEL = 1;
endpackage

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       tickEn,
  input  logic       rdEn,
  input  logic       rdAddr,
  input  logic       preShort,
  input  logic       preLong,
  output tmrStrobe_t strobe,
  output logic       irqShort,
  output logic       irqLong
);
  always_comb begin
    strobe.advance   = tickEn & ~rst;
    strobe.readOn    = rdEn;
    strobe.selHi     = (rdAddr == 1'(HI_SEL));
    strobe.captureHi = rdEn & (rdAddr == 1'(LO_SEL)) & ~rst;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irqShort <= 1'b0;
      irqLong  <= 1'b0;
    end else begin
      irqShort <= tickEn & preShort;
      irqLong  <= tickEn & preLong;
    end
  end

  // R6: reset never produces a request in the following cycle
  p_no_irq_after_reset_r6: assert property (@(posedge clk)
    rst |=> (!irqShort && !irqLong));
  // R3: short request is a single-clock pulse
  p_short_single_r3: assert property (@(posedge clk) disable iff (rst)
    irqShort |=> !irqShort);
  // R4: long request is a single-clock pulse aligned with a short one
  p_long_single_r4: assert property (@(posedge clk) disable iff (rst)
    irqLong |=> !irqLong);
  p_long_with_short_r4: assert property (@(posedge clk) disable iff (rst)
    irqLong |-> irqShort);
endmodule

// File: rtl/tick_timer_datapath.sv
module tick_timer_datapath
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned SHORT_BITS = 7,
  parameter int unsigned LONG_BITS  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  tmrStrobe_t        strobe,
  output logic              preShort,
  output logic              preLong,
  output logic [BYTE_W-1:0] rdData
);
  localparam int unsigned HI_W  = CNT_W - BYTE_W;
  localparam int unsigned PAD_W = BYTE_W - HI_W;

  logic [CNT_W-1:0] count;
  logic [HI_W-1:0]  holdHi;

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (strobe.advance) begin
      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      holdHi <= '0;
    end else if (strobe.captureHi) begin
      holdHi <= count[CNT_W-1:BYTE_W];
    end
  end

  // Low bits all ones: the next tick rolls the field over to zero
  assign preShort = &count[SHORT_BITS-1:0];
  assign preLong  = &count[LONG_BITS-1:0];

  always_comb begin
    if (!strobe.readOn)   rdData = '0;
    else if (strobe.selHi) rdData = {{PAD_W{1'b0}}, holdHi};
    else                   rdData = count[BYTE_W-1:0];
  end

  // R1: counts exactly one per tick
  p_count_step_r1: assert property (@(posedge clk) disable iff (rst)
    strobe.advance |=> count == $past(count) + 1'b1);
  p_count_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !strobe.advance |=> $stable(count));
  // R7: wrap from all ones to zero
  p_wrap_r7: assert property (@(posedge clk) disable iff (rst)
    (strobe.advance && (&count)) |=> (count == '0));
  // R5: holding register only changes on a low-byte read
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !strobe.captureHi |=> $stable(holdHi));
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int unsigned CNT_W      = 12,
  parameter int unsigned BYTE_W     = 8,
  parameter int unsigned SHORT_BITS = 7,
  parameter int unsigned LONG_BITS  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tickEn,
  input  logic              rdEn,
  input  logic              rdAddr,
  output logic [BYTE_W-1:0] rdData,
  output logic              irqShort,
  output logic              irqLong
);
  import tick_timer_pkg::*;

  tmrStrobe_t strobe;
  logic       preShort;
  logic       preLong;

  tick_timer_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tickEn   (tickEn),
    .rdEn     (rdEn),
    .rdAddr   (rdAddr),
    .preShort (preShort),
    .preLong  (preLong),
    .strobe   (strobe),
    .irqShort (irqShort),
    .irqLong  (irqLong)
  );

  tick_timer_datapath #(
    .CNT_W      (CNT_W),
    .BYTE_W     (BYTE_W),
    .SHORT_BITS (SHORT_BITS),
    .LONG_BITS  (LONG_BITS)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .preShort (preShort),
    .preLong  (preLong),
    .rdData   (rdData)
  );
endmodule

// File: tb/tick_timer_bench.sv
module tick_timer_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tickEn = 1'b0;
  logic       rdEn = 1'b0;
  logic       rdAddr = 1'b0;
  logic [7:0] rdData;
  logic       irqShort, irqLong;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit finished = 0;
  int tickMode = 0;   // 0 none, 1 every clock, 2 every fifth, 3 manual
  int phase = 0;

  // reference model, from the requirements
  logic [11:0] mc = '0;
  logic [3:0]  mh = '0;
  logic        expShort = 0, expLong = 0;

  logic [7:0] expQ[$];
  string      tagQ[$];

  tick_timer u_tick_timer (
    .clk(clk), .rst(rst), .tickEn(tickEn), .rdEn(rdEn), .rdAddr(rdAddr),
    .rdData(rdData), .irqShort(irqShort), .irqLong(irqLong)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      mc <= '0; mh <= '0; expShort <= 0; expLong <= 0;
    end else begin
      if (tickEn) mc <= mc + 12'd1;
      expShort <= tickEn && (mc[6:0] == 7'h7F);
      expLong  <= tickEn && (mc[9:0] == 10'h3FF);
      if (rdEn && rdAddr == 1'b0) mh <= mc[11:8];
    end
  end

  // tick generator
  always @(negedge clk) begin
    if (tickMode == 1)      tickEn <= 1'b1;
    else if (tickMode == 2) tickEn <= (phase % 5 == 0);
    else if (tickMode == 0) tickEn <= 1'b0;
    phase <= phase + 1;
  end

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    #2;
    if (!rst || finished) begin end
    if (rdEn) begin
      if (expQ.size() == 0) check("R2 queue", 8'hEE, 8'h00);
      else check(tagQ.pop_front(), rdData, expQ.pop_front());
    end else if (cycles > 2 && !rst) begin
      if (rdData !== 8'h00) check("R8 idle rdData", rdData, 8'h00);
    end
    if (irqShort || expShort) check("R3 irqShort", {7'd0, irqShort}, {7'd0, expShort});
    if (irqLong || expLong)   check("R4 irqLong", {7'd0, irqLong}, {7'd0, expLong});
  end

  // driver: read one register; expected pushed from the model state
  task automatic doRead(input logic addr, input string tag);
    @(negedge clk);
    rdEn   = 1'b1;
    rdAddr = addr;
    expQ.push_back(addr ? {4'h0, mh} : mc[7:0]);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic finish;
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  endtask

  initial begin
    idle(3);
    rst = 1'b0;
    // reset state
    doRead(1'b0, "R6 reset low byte");
    doRead(1'b1, "R6 reset high byte");
    check("R8 idle after reset", rdData, 8'h00);

    // R1 dense ticks
    tickMode = 1;
    idle(300);
    doRead(1'b0, "R1 dense low");
    doRead(1'b1, "R5 dense high");

    // R1 no ticks: value holds
    tickMode = 0;
    idle(2);
    doRead(1'b0, "R1 hold first");
    idle(20);
    doRead(1'b0, "R1 hold second");

    // sparse ticks
    tickMode = 2;
    idle(1500);
    doRead(1'b0, "R2 sparse low");
    doRead(1'b1, "R5 sparse high");

    // R5 coherent read across 0xFF carry
    tickMode = 1;
    while (mc[7:0] != 8'hFE) @(negedge clk);
    doRead(1'b0, "R5 low before carry");
    idle(3);
    doRead(1'b1, "R5 high after carry (stale hold)");
    doRead(1'b0, "R2 low after carry");
    doRead(1'b1, "R5 high refreshed");

    // R7 full wrap
    while (mc != 12'hFFE) @(negedge clk);
    doRead(1'b0, "R7 low near wrap");
    doRead(1'b1, "R8 high near wrap upper nibble zero");
    idle(4);
    doRead(1'b0, "R7 low after wrap");
    doRead(1'b1, "R7 high after wrap");

    // R6 reset at a rollover edge
    while (mc[6:0] != 7'h7F) @(negedge clk);
    tickMode = 3;
    tickEn = 1'b1;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    tickEn = 1'b0;
    #2;
    check("R6 no irqShort after reset", {7'd0, irqShort}, 8'h00);
    check("R6 no irqLong after reset", {7'd0, irqLong}, 8'h00);
    doRead(1'b0, "R6 low after reset");
    doRead(1'b1, "R6 high after reset");

    // another pass of full wraps
    tickMode = 1;
    idle(9000);
    tickMode = 0;
    idle(3);
    doRead(1'b0, "R1 final low");
    doRead(1'b1, "R5 final high");
    idle(3);
    finish();
  end

  initial begin
    wait (cycles > 150000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish();
    end
  end
endmodule